// File: doc/BRIEF.md
# Subroutine Return Stack Unit

This unit holds the return addresses of a small 8-bit processor core and chooses the program counter for the next instruction cycle. The instruction decoder drives one strobe for each control event: a subroutine call, a plain return, a return that also loads an 8-bit constant into the working register, a return from an interrupt handler, and interrupt entry. The unit also receives the constant, the current program counter, an 11-bit call target and a page-select field.

A call or an interrupt entry pushes an address onto an 8-entry circular stack of 13-bit addresses. All three kinds of return use the same pop path, and each takes two instruction cycles. In the cycle after a return, the unit raises a squash output. During that cycle the instruction already fetched runs as a no-op, and every strobe is ignored. Two of the returns have a side effect. The constant return writes the working register, and the interrupt return sets the global interrupt enable bit. No return changes any status flag.

Top module: `ret_stack_unit`

## Requirements
- R1: After reset, `gie_o` is 0 and `squash_o` is 0. In any cycle with no strobe and no squash, `pc_next_o` equals `pc_i + 1` and `w_we_o` is 0.
- R2: A call pushes `pc_i + 1` onto the stack. In the same cycle, `pc_next_o` is `{page_i, tgt_i}`, with the page field in bits 12:11 and the target in bits 10:0.
- R3: A plain return drives `pc_next_o` with the most recently pushed address in the same cycle and pops that entry.
- R4: A constant return drives `w_we_o` = 1 and `w_data_o` = `lit_i` in the same cycle. It also loads `pc_next_o` from the top of stack and pops that entry. Both constant values 0x00 and 0xFF are carried unchanged.
- R5: An interrupt return loads `pc_next_o` from the top of stack and pops that entry. `gie_o` reads 1 from the next cycle onward.
- R6: Every return kind raises `squash_o` for exactly the next cycle. In that cycle all strobes are ignored: `pc_next_o` is `pc_i + 1`, `w_we_o` is 0, and neither the stack nor `gie_o` changes.
- R7: Interrupt entry pushes `pc_i` and drives `pc_next_o` = 0x004 in the same cycle. `gie_o` reads 0 from the next cycle onward.
- R8: Up to 8 nested pushes come back in reverse order when popped.
- R9: The stack is circular and has no overflow or underflow flag. A ninth push overwrites the oldest entry. Nine pushes followed by nine pops return the 9th, 8th, down to the 2nd pushed address, and then the 9th again.
- R10: When several strobes are high together, only one takes effect. The order from highest to lowest is: interrupt entry, call, interrupt return, constant return, plain return.
- R11: `w_we_o` is 1 only in a cycle where the constant return takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Subroutine call strobe |
| ret_i | input | 1 | Plain return strobe |
| retlw_i | input | 1 | Return-with-constant strobe |
| retfie_i | input | 1 | Return-from-interrupt strobe |
| irq_i | input | 1 | Interrupt entry strobe |
| lit_i | input | 8 | Constant for the working register |
| pc_i | input | 13 | Current program counter |
| tgt_i | input | 11 | Call target (low address bits) |
| page_i | input | 2 | Page select (upper address bits of a call) |
| pc_next_o | output | 13 | Program counter for the next cycle |
| w_we_o | output | 1 | Working register write strobe |
| w_data_o | output | 8 | Working register write value |
| gie_o | output | 1 | Global interrupt enable |
| squash_o | output | 1 | Current fetched instruction is discarded |

## Verification
The assertions check on every cycle the local rules of the design. The stack pointer moves by one on each push or pop, and a push is visible at the top of stack in the next cycle. Every return is followed by exactly one squash cycle, and no write strobe appears during it. The interrupt enable bit follows interrupt entry and interrupt return, and a working register write appears only with a constant return. Some behaviour can only be shown by the bench's scenarios, because it depends on whole sequences and not on single cycles. These cases are the reverse order of eight nested calls, the overwrite and wrap that follow a ninth push, strobes ignored in a squash cycle, the priority between strobes raised together, and the exact addresses and constants that reach the outputs.

// File: rtl/retstk_pkg.sv
package retstk_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_CALL   = 3'd1,
    OP_RET    = 3'd2,
    OP_RETLW  = 3'd3,
    OP_RETFIE = 3'd4,
    OP_IRQ    = 3'd5
  } op_e;

  function automatic logic is_return(op_e op);
    return (op == OP_RET) || (op == OP_RETLW) || (op == OP_RETFIE);
  endfunction
endpackage

// File: rtl/retstk_decode.sv
module retstk_decode
  import retstk_pkg::*;
(
  input  logic call_i,
  input  logic ret_i,
  input  logic retlw_i,
  input  logic retfie_i,
  input  logic irq_i,
  input  logic squash_i,
  output op_e  op_o
);
  // Fixed priority; nothing is accepted during a squash cycle.
  always_comb begin
    op_o = OP_NONE;
    if (!squash_i) begin
      if (irq_i)         op_o = OP_IRQ;
      else if (call_i)   op_o = OP_CALL;
      else if (retfie_i) op_o = OP_RETFIE;
      else if (retlw_i)  op_o = OP_RETLW;
      else if (ret_i)    op_o = OP_RET;
    end
  end
endmodule

// File: rtl/retstk_lifo.sv
module retstk_lifo #(
  parameter int AW    = 13,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] tos_o
);
  localparam int PW = $clog2(DEPTH);

  logic [AW-1:0] slot_q [DEPTH];
  logic [PW-1:0] ptr_q, ptr_d;
  logic [PW-1:0] top_idx;

  assign top_idx = ptr_q - PW'(1);
  assign tos_o   = slot_q[top_idx];

  always_comb begin
    ptr_d = ptr_q;
    if (push_i)     ptr_d = ptr_q + PW'(1);
    else if (pop_i) ptr_d = ptr_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // Storage has no reset; only the pointer does.
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push_i && (ptr_q == PW'(g))) slot_q[g] <= wdata_i;
      end
    end
  endgenerate

  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> ptr_q == $past(ptr_q) + PW'(1));
  p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> ptr_q == $past(ptr_q) - PW'(1));
  p_push_on_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> tos_o == $past(wdata_i));
endmodule

// File: rtl/retstk_seq.sv
module retstk_seq
  import retstk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_e  op_i,
  output logic squash_o,
  output logic gie_o
);
  logic squash_d, gie_d, gie_en;

  assign gie_en = (op_i == OP_IRQ) || (op_i == OP_RETFIE);

  always_comb begin
    squash_d = is_return(op_i);
    gie_d    = gie_o;
    if (gie_en) gie_d = (op_i == OP_RETFIE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      squash_o <= 1'b0;
      gie_o    <= 1'b0;
    end else begin
      squash_o <= squash_d;
      if (gie_en) gie_o <= gie_d;
    end
  end

  p_ret_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_return(op_i) |=> squash_o);
  p_single_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |=> !squash_o);
  p_gie_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_RETFIE) |=> gie_o);
  p_gie_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_IRQ) |=> !gie_o);
  p_gie_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |=> $stable(gie_o));
endmodule

// File: rtl/ret_stack_unit.sv
module ret_stack_unit
  import retstk_pkg::*;
#(
  parameter int              AW    = 13,
  parameter int              DW    = 8,
  parameter int              TW    = 11,
  parameter int              DEPTH = 8,
  parameter logic [AW-1:0]   VEC   = 13'h004
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             retlw_i,
  input  logic             retfie_i,
  input  logic             irq_i,
  input  logic [DW-1:0]    lit_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [TW-1:0]    tgt_i,
  input  logic [AW-TW-1:0] page_i,
  output logic [AW-1:0]    pc_next_o,
  output logic             w_we_o,
  output logic [DW-1:0]    w_data_o,
  output logic             gie_o,
  output logic             squash_o
);
  op_e           op;
  logic          push, pop;
  logic [AW-1:0] pc_inc, push_val, tos;

  assign pc_inc = pc_i + AW'(1);

  retstk_decode u_decode (
    .call_i   (call_i),
    .ret_i    (ret_i),
    .retlw_i  (retlw_i),
    .retfie_i (retfie_i),
    .irq_i    (irq_i),
    .squash_i (squash_o),
    .op_o     (op)
  );

  assign push     = (op == OP_CALL) || (op == OP_IRQ);
  assign pop      = is_return(op);
  assign push_val = (op == OP_IRQ) ? pc_i : pc_inc;

  retstk_lifo #(.AW(AW), .DEPTH(DEPTH)) u_lifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (push_val),
    .tos_o   (tos)
  );

  retstk_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op),
    .squash_o (squash_o),
    .gie_o    (gie_o)
  );

  always_comb begin
    pc_next_o = pc_inc;
    w_we_o    = 1'b0;
    w_data_o  = '0;
    case (op)
      OP_IRQ:    pc_next_o = VEC;
      OP_CALL:   pc_next_o = {page_i, tgt_i};
      OP_RET,
      OP_RETFIE: pc_next_o = tos;
      OP_RETLW: begin
        pc_next_o = tos;
        w_we_o    = 1'b1;
        w_data_o  = lit_i;
      end
      default:   pc_next_o = pc_inc;
    endcase
  end

  p_no_write_in_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |-> !w_we_o);
  p_write_needs_lit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    w_we_o |-> (retlw_i && !irq_i && !call_i && !retfie_i));
  p_bubble_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |-> pc_next_o == pc_i + AW'(1));
endmodule

// File: tb/ret_stack_unit_tb.sv
module ret_stack_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        call_i, ret_i, retlw_i, retfie_i, irq_i;
  logic [7:0]  lit_i;
  logic [12:0] pc_i;
  logic [10:0] tgt_i;
  logic [1:0]  page_i;
  logic [12:0] pc_next_o;
  logic        w_we_o, gie_o, squash_o;
  logic [7:0]  w_data_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [12:0] pc;
    logic        we;
    logic [7:0]  wd;
    logic        gie;
    logic        sq;
    string       tag;
  } exp_t;
  exp_t q[$];

  // reference state, derived from the requirements
  logic [12:0] mstk [8];
  int          mptr = 0;
  logic        mgie = 1'b0;
  logic        msq  = 1'b0;

  always #2 clk = ~clk;

  ret_stack_unit u_dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .retlw_i(retlw_i), .retfie_i(retfie_i), .irq_i(irq_i), .lit_i(lit_i),
    .pc_i(pc_i), .tgt_i(tgt_i), .page_i(page_i), .pc_next_o(pc_next_o),
    .w_we_o(w_we_o), .w_data_o(w_data_o), .gie_o(gie_o), .squash_o(squash_o)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  function automatic void mpush(input logic [12:0] v);
    mstk[mptr] = v;
    mptr = (mptr + 1) % 8;
  endfunction

  function automatic logic [12:0] mpop();
    mptr = (mptr + 7) % 8;
    return mstk[mptr];
  endfunction

  // driver: apply one cycle of stimulus and queue its expected result
  task automatic step(input logic c, input logic r, input logic l, input logic f,
                      input logic i, input logic [7:0] k, input logic [12:0] pc,
                      input logic [10:0] tg, input logic [1:0] pg, input string tag);
    exp_t e;
    logic nsq;
    logic ngie;
    @(negedge clk);
    call_i = c; ret_i = r; retlw_i = l; retfie_i = f; irq_i = i;
    lit_i = k; pc_i = pc; tgt_i = tg; page_i = pg;
    e.tag = tag; e.gie = mgie; e.sq = msq; e.we = 1'b0; e.wd = 8'h00;
    e.pc = pc + 13'd1;
    nsq = 1'b0; ngie = mgie;
    if (!msq) begin
      if (i) begin
        mpush(pc); e.pc = 13'h004; ngie = 1'b0;
      end else if (c) begin
        mpush(pc + 13'd1); e.pc = {pg, tg};
      end else if (f) begin
        e.pc = mpop(); ngie = 1'b1; nsq = 1'b1;
      end else if (l) begin
        e.pc = mpop(); e.we = 1'b1; e.wd = k; nsq = 1'b1;
      end else if (r) begin
        e.pc = mpop(); nsq = 1'b1;
      end
    end
    msq = nsq; mgie = ngie;
    q.push_back(e);
  endtask

  // monitor: compare outputs against queued expectations mid-cycle
  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pc_next_o !== e.pc || w_we_o !== e.we || gie_o !== e.gie ||
          squash_o !== e.sq || (e.we && w_data_o !== e.wd)) begin
        errors++;
        $display("FAIL %s pc/we/wd/gie/sq got %h/%b/%h/%b/%b exp %h/%b/%h/%b/%b",
                 e.tag, pc_next_o, w_we_o, w_data_o, gie_o, squash_o,
                 e.pc, e.we, e.wd, e.gie, e.sq);
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    call_i = 0; ret_i = 0; retlw_i = 0; retfie_i = 0; irq_i = 0;
    lit_i = 0; pc_i = 13'h010; tgt_i = 0; page_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "gie", int'(gie_o), 0);
    chk("R1", "squash", int'(squash_o), 0);
    chk("R1", "pc_next", int'(pc_next_o), 13'h011);

    step(0,0,0,0,0, 8'h00, 13'h020, 11'h0, 2'd0, "R1 idle");

    // R8: eight nested calls, unwound with mixed return kinds
    for (int n = 0; n < 8; n++)
      step(1,0,0,0,0, 8'h00, 13'h100 + 13'(n * 16), 11'(n * 3 + 5), 2'(n), "R2/R8 call");
    for (int n = 0; n < 8; n++) begin
      if (n % 2 == 0)
        step(0,0,1,0,0, (n % 4 == 0) ? 8'h00 : 8'hFF, 13'h400 + 13'(n), 11'h0, 2'd0, "R4/R8 retlw");
      else
        step(0,1,0,0,0, 8'h5A, 13'h400 + 13'(n), 11'h0, 2'd0, "R3/R8/R11 ret");
      // bubble cycle: every strobe raised, all must be ignored
      step(1,1,1,1,1, 8'h77, 13'h500 + 13'(n), 11'h3FF, 2'd3, "R6 squash");
    end

    // R9: nine pushes, nine pops
    for (int n = 0; n < 9; n++)
      step(1,0,0,0,0, 8'h00, 13'h0A0 + 13'(n * 2), 11'h123, 2'd1, "R9 push");
    for (int n = 0; n < 9; n++) begin
      step(0,1,0,0,0, 8'h00, 13'h700, 11'h0, 2'd0, "R9 pop");
      step(0,0,0,0,0, 8'h00, 13'h710, 11'h0, 2'd0, "R6 idle bubble");
    end

    // R7 then R5
    step(0,0,0,0,1, 8'h00, 13'h055, 11'h0, 2'd0, "R7 irq");
    step(0,0,0,0,0, 8'h00, 13'h004, 11'h0, 2'd0, "R7 gie low");
    step(0,0,0,1,0, 8'h00, 13'h006, 11'h0, 2'd0, "R5 retfie");
    step(0,0,0,0,0, 8'h00, 13'h055, 11'h0, 2'd0, "R5 gie high");
    step(0,0,0,0,0, 8'h00, 13'h056, 11'h0, 2'd0, "R5 gie held");

    // R10 priority
    step(1,1,1,1,1, 8'h33, 13'h200, 11'h055, 2'd2, "R10 irq wins");
    step(1,1,1,1,0, 8'h33, 13'h210, 11'h066, 2'd1, "R10 call wins");
    step(0,1,1,1,0, 8'h44, 13'h220, 11'h0, 2'd0, "R10 retfie wins");
    step(0,0,0,0,0, 8'h00, 13'h230, 11'h0, 2'd0, "R6 bubble");
    step(0,1,1,0,0, 8'hC3, 13'h240, 11'h0, 2'd0, "R10/R11 retlw over ret");
    step(0,0,0,0,0, 8'h00, 13'h250, 11'h0, 2'd0, "R1 idle end");

    repeat (3) @(negedge clk);
    #2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule